// File: doc/BRIEF.md
# Exception Entry Vector and Status Capture Unit

This unit supports exception entry in a small 32-bit processor. Software loads a vector base register that points at a 4 KB dispatch table. The table holds 256 slots of 16 bytes each, which is room for four instructions per slot. When the core accepts an exception, interrupt or trap, it pulses `accept` and presents an 8-bit vector number. One cycle later the unit returns the slot address, together with a single-cycle valid pulse. The address is built by OR-ing the 4 KB-aligned base with the vector number shifted left by four.

On the same accept strobe, the low half of the live status word is copied into a saved-status register. The upper half of that register is not stored: reads always return the current upper half of the live status word. The unit also gives a read-only view of sixteen external request levels. Each level shows its request line after two synchronizing flops, with no masking, so the top level appears like every other level.

The entry path is a two-state machine. `ENT_IDLE` means no address is being issued. `ENT_ISSUE` means `entry_valid` is high for this cycle. The transition idle→issue is taken on an accept. issue→issue is taken on back-to-back accepts. issue→idle and idle→idle are taken when no accept is present.

Top module: `exc_entry_unit`

## Requirements
- R1: The cycle after `accept` is high, `entry_addr` equals {base[31:12], 12'b0} bitwise-OR (vec_num << 4). Bits [3:0] are zero and bits [11:4] hold the vector number.
- R2: `entry_valid` is high in exactly those cycles that follow a cycle with `accept` high, and low otherwise. The state machine moves idle→issue, issue→issue, issue→idle and idle→idle as described above.
- R3: A write with `reg_sel`=0 stores only `reg_wdata[31:12]` into the vector base. A read with `reg_sel`=0 returns the stored bits with bits [11:0] reading as zero. The base has no reset value.
- R4: An accept copies `live_status[15:0]` into the saved-status low half. A read with `reg_sel`=1 shows the copied value from the next cycle on.
- R5: A read with `reg_sel`=1 always returns `live_status[31:16]` in bits [31:16], taken in the same cycle.
- R6: A write with `reg_sel`=1 and no accept loads `reg_wdata[15:0]` into the saved-status low half. The upper 16 data bits are ignored.
- R7: When a `reg_sel`=1 write and an accept fall in the same cycle, the captured status wins.
- R8: A read with `reg_sel`=2 returns `irq_lines` in bits [15:0], two clocks late, with bits [31:16] zero. Bit 15 is the non-maskable level, and no level is masked.
- R9: Writes with `reg_sel`=2 or 3 change no register. Reads with `reg_sel`=3 return zero.
- R10: While reset is low, `entry_valid` and `entry_addr` are zero, the saved-status low half is zero and the request view is zero.
- R11: If a base write and an accept fall in the same cycle, the issued address uses the base held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 base, 1 saved status, 2 requests, 3 none |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| live_status | input | 32 | Current processor status word |
| accept | input | 1 | Exception/interrupt/trap accepted this cycle |
| vec_num | input | 8 | Vector number of the accepted event |
| irq_lines | input | 16 | External request levels, bit 15 non-maskable |
| entry_addr | output | 32 | Registered dispatch slot address |
| entry_valid | output | 1 | One-cycle pulse marking entry_addr valid |

## Verification
The embedded assertions check several rules on every cycle. They check that the valid pulse follows accept by exactly one cycle and that the issued slot bits repeat the previous vector number. They check that the saved-status low half follows either the capture or the software write, with capture taking priority. They also check that the saved-status upper half always mirrors the live word and that the request view lags the lines by two clocks. Only the bench scenarios can show the full address values for different bases, the old-base choice when a base write meets an accept, the ignored writes to the request and spare selects, and the reset values seen at the ports.

// File: rtl/exc_pkg.sv
package exc_pkg;
    typedef enum logic [1:0] {
        SEL_VBASE = 2'd0,
        SEL_SSTAT = 2'd1,
        SEL_IREQ  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ENT_IDLE  = 1'b0,
        ENT_ISSUE = 1'b1
    } ent_state_e;
endpackage

// File: rtl/exc_vbase.sv
module exc_vbase #(
    parameter int DATA_W = 32,
    parameter int ALIGN_W = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [DATA_W-ALIGN_W-1:0] wdata_hi,
    output logic [DATA_W-ALIGN_W-1:0] base_hi
);
    // No reset: the base is undefined until software loads it.
    always_ff @(posedge clk) begin
        if (wr_en) base_hi <= wdata_hi;
    end

    // R3
    vbase_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> base_hi == $past(wdata_hi));
endmodule

// File: rtl/exc_entry_gen.sv
module exc_entry_gen
    import exc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int VEC_W = 8,
    parameter int SLOT_SHIFT = 4,
    localparam int ALIGN_W = VEC_W + SLOT_SHIFT
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      accept,
    input  logic [VEC_W-1:0]          vec,
    input  logic [DATA_W-ALIGN_W-1:0] base_hi,
    output logic [DATA_W-1:0]         entry_addr,
    output logic                      entry_valid
);
    ent_state_e state_q, state_d;
    logic [DATA_W-1:0] addr_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENT_IDLE:  state_d = accept ? ENT_ISSUE : ENT_IDLE;
            ENT_ISSUE: state_d = accept ? ENT_ISSUE : ENT_IDLE;
            default:   state_d = ENT_IDLE;
        endcase
    end

    always_comb begin
        addr_d = {base_hi, {ALIGN_W{1'b0}}} | (DATA_W'(vec) << SLOT_SHIFT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      entry_addr <= '0;
        else if (accept) entry_addr <= addr_d;
    end

    assign entry_valid = (state_q == ENT_ISSUE);

    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_valid == ($past(accept) && $past(rst_n)));
    // R1
    slot_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_valid |-> entry_addr[ALIGN_W-1:SLOT_SHIFT] == $past(vec));
    // R1
    slot_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_valid |-> entry_addr[SLOT_SHIFT-1:0] == '0);
endmodule

// File: rtl/exc_saved_status.sv
module exc_saved_status #(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [HALF_W-1:0] live_lo,
    input  logic              wr_en,
    input  logic [HALF_W-1:0] wdata_lo,
    output logic [HALF_W-1:0] saved_lo
);
    always_ff @(posedge clk) begin
        if (!rst_n)      saved_lo <= '0;
        else if (accept) saved_lo <= live_lo;
        else if (wr_en)  saved_lo <= wdata_lo;
    end

    // R4 R7
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(accept) && $past(rst_n)) |-> saved_lo == $past(live_lo));
    // R6
    sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && !$past(accept) && $past(rst_n)) |-> saved_lo == $past(wdata_lo));
endmodule

// File: rtl/exc_irq_sync.sv
module exc_irq_sync #(
    parameter int IRQ_N = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_N-1:0] irq_in,
    output logic [IRQ_N-1:0] irq_vis
);
    logic [IRQ_N-1:0] stage_q [SYNC_STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n)       stage_q[gi] <= '0;
                else if (gi == 0) stage_q[gi] <= irq_in;
                else              stage_q[gi] <= stage_q[(gi == 0) ? 0 : gi-1];
            end
        end
    endgenerate

    assign irq_vis = stage_q[SYNC_STAGES-1];

    generate
        if (SYNC_STAGES == 2) begin : g_lat_chk
            logic [1:0] warm_q;
            always_ff @(posedge clk) begin
                if (!rst_n)             warm_q <= '0;
                else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
            end
            // R8
            irq_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (warm_q == 2'd2) |-> irq_vis == $past(irq_in, 2));
        end
    endgenerate
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int VEC_W = 8,
    parameter int SLOT_SHIFT = 4,
    parameter int IRQ_N = 16,
    parameter int SYNC_STAGES = 2,
    localparam int ALIGN_W = VEC_W + SLOT_SHIFT,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] live_status,
    input  logic              accept,
    input  logic [VEC_W-1:0]  vec_num,
    input  logic [IRQ_N-1:0]  irq_lines,
    output logic [DATA_W-1:0] entry_addr,
    output logic              entry_valid
);
    reg_sel_e sel;
    logic [DATA_W-ALIGN_W-1:0] base_hi;
    logic [HALF_W-1:0] saved_lo;
    logic [IRQ_N-1:0] irq_vis;

    assign sel = reg_sel_e'(reg_sel);

    exc_vbase #(.DATA_W(DATA_W), .ALIGN_W(ALIGN_W)) u_vbase (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr && sel == SEL_VBASE),
        .wdata_hi(reg_wdata[DATA_W-1:ALIGN_W]),
        .base_hi(base_hi)
    );

    exc_entry_gen #(.DATA_W(DATA_W), .VEC_W(VEC_W), .SLOT_SHIFT(SLOT_SHIFT)) u_entry (
        .clk(clk), .rst_n(rst_n), .accept(accept), .vec(vec_num),
        .base_hi(base_hi), .entry_addr(entry_addr), .entry_valid(entry_valid)
    );

    exc_saved_status #(.HALF_W(HALF_W)) u_sstat (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .live_lo(live_status[HALF_W-1:0]),
        .wr_en(reg_wr && sel == SEL_SSTAT),
        .wdata_lo(reg_wdata[HALF_W-1:0]),
        .saved_lo(saved_lo)
    );

    exc_irq_sync #(.IRQ_N(IRQ_N), .SYNC_STAGES(SYNC_STAGES)) u_irq (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_lines), .irq_vis(irq_vis)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_VBASE: reg_rdata = {base_hi, {ALIGN_W{1'b0}}};
            SEL_SSTAT: reg_rdata = {live_status[DATA_W-1:HALF_W], saved_lo};
            SEL_IREQ:  reg_rdata = DATA_W'(irq_vis);
            SEL_NONE:  reg_rdata = '0;
            default:   reg_rdata = '0;
        endcase
    end

    // R5
    upper_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd1) |-> reg_rdata[DATA_W-1:HALF_W] == live_status[DATA_W-1:HALF_W]);
    // R9
    spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd3) |-> reg_rdata == '0);
endmodule

// File: tb/exc_entry_unit_bench.sv
module exc_entry_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd3;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] live_status = '0;
    logic        accept = 1'b0;
    logic [7:0]  vec_num = '0;
    logic [15:0] irq_lines = '0;
    logic [31:0] entry_addr;
    logic        entry_valid;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    exc_entry_unit u_exc_entry_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .live_status(live_status),
        .accept(accept), .vec_num(vec_num), .irq_lines(irq_lines),
        .entry_addr(entry_addr), .entry_valid(entry_valid)
    );

    // {base written, vector number}
    localparam logic [39:0] VEC_TBL [6] = '{
        {32'h0000_0000, 8'h00},
        {32'h1234_5FFF, 8'h01},
        {32'hFFFF_F000, 8'hFF},
        {32'h8000_0ABC, 8'h80},
        {32'hDEAD_BEEF, 8'h5A},
        {32'h0001_2000, 8'h3C}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [31:0] data);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] sel, output logic [31:0] data);
        reg_sel = sel;
        #1 data = reg_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, base, exp_addr;
        logic [7:0] v;
        @(negedge clk);
        repeat (3) tick();
        // R10 reset values
        check("R10 valid", {31'b0, entry_valid}, 32'd0);
        check("R10 addr", entry_addr, 32'd0);
        live_status = 32'hA5A5_0000;
        read_reg(2'd1, rd);
        check("R10 saved", rd, 32'hA5A5_0000);
        irq_lines = 16'hFFFF;
        tick();
        read_reg(2'd2, rd);
        check("R10 irq", rd, 32'd0);
        irq_lines = '0;
        rst_n = 1'b1;
        tick(); tick();

        // R1 R3 vector table walk
        for (int i = 0; i < 6; i++) begin
            base = VEC_TBL[i][39:8];
            v = VEC_TBL[i][7:0];
            write_reg(2'd0, base);
            read_reg(2'd0, rd);
            check("R3 base readback", rd, base & 32'hFFFF_F000);
            accept = 1'b1; vec_num = v;
            tick();
            accept = 1'b0;
            exp_addr = (base & 32'hFFFF_F000) | ({24'd0, v} << 4);
            check("R2 valid pulse", {31'b0, entry_valid}, 32'd1);
            check("R1 entry addr", entry_addr, exp_addr);
            tick();
            check("R2 valid drop", {31'b0, entry_valid}, 32'd0);
        end

        // R2 back-to-back accepts keep valid high
        write_reg(2'd0, 32'h4000_0000);
        accept = 1'b1; vec_num = 8'h10;
        tick();
        vec_num = 8'h11;
        check("R2 b2b first", {31'b0, entry_valid}, 32'd1);
        check("R1 b2b addr0", entry_addr, 32'h4000_0100);
        tick();
        accept = 1'b0;
        check("R2 b2b second", {31'b0, entry_valid}, 32'd1);
        check("R1 b2b addr1", entry_addr, 32'h4000_0110);
        tick();
        check("R2 b2b end", {31'b0, entry_valid}, 32'd0);

        // R11 base write same cycle as accept uses old base
        reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 32'h7777_7000;
        accept = 1'b1; vec_num = 8'h02;
        tick();
        reg_wr = 1'b0; accept = 1'b0;
        check("R11 old base", entry_addr, 32'h4000_0020);
        read_reg(2'd0, rd);
        check("R11 new base stored", rd, 32'h7777_7000);

        // R4 capture, R5 upper mirror
        live_status = 32'h1111_BEEF;
        accept = 1'b1; vec_num = 8'h00;
        tick();
        accept = 1'b0;
        live_status = 32'h2222_0000;
        read_reg(2'd1, rd);
        check("R4 capture", rd, 32'h2222_BEEF);
        live_status = 32'h9999_0001;
        #1 check("R5 upper tracks live", reg_rdata, 32'h9999_BEEF);

        // R6 software write, upper data ignored
        write_reg(2'd1, 32'hFFFF_1234);
        read_reg(2'd1, rd);
        check("R6 sw write", rd, 32'h9999_1234);

        // R7 write and accept together: capture wins
        live_status = 32'h0000_CAFE;
        reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 32'h0000_5555;
        accept = 1'b1;
        tick();
        reg_wr = 1'b0; accept = 1'b0;
        read_reg(2'd1, rd);
        check("R7 capture priority", rd, 32'h0000_CAFE);

        // R8 two-clock latency, bit 15 passes unmasked
        reg_sel = 2'd2;
        irq_lines = 16'h8001;
        tick();
        read_reg(2'd2, rd);
        check("R8 after one clock", rd, 32'd0);
        tick();
        read_reg(2'd2, rd);
        check("R8 after two clocks", rd, 32'h0000_8001);
        irq_lines = 16'h0240;
        tick(); tick();
        read_reg(2'd2, rd);
        check("R8 level change", rd, 32'h0000_0240);
        irq_lines = 16'h0000;
        tick(); tick();
        read_reg(2'd2, rd);
        check("R8 release clears", rd, 32'd0);

        // R9 writes to request and spare selects change nothing
        irq_lines = 16'h0003;
        tick(); tick();
        write_reg(2'd2, 32'hFFFF_FFFF);
        read_reg(2'd2, rd);
        check("R9 irq write ignored", rd, 32'h0000_0003);
        write_reg(2'd3, 32'hFFFF_FFFF);
        read_reg(2'd3, rd);
        check("R9 spare reads zero", rd, 32'd0);
        read_reg(2'd0, rd);
        check("R9 base unchanged", rd, 32'h7777_7000);
        live_status = 32'h0000_0000;
        read_reg(2'd1, rd);
        check("R9 saved unchanged", rd, 32'h0000_CAFE);

        // R10 reset in mid-run clears valid, addr, saved, requests
        accept = 1'b1; vec_num = 8'h44;
        rst_n = 1'b0;
        tick();
        accept = 1'b0;
        check("R10 valid in reset", {31'b0, entry_valid}, 32'd0);
        check("R10 addr in reset", entry_addr, 32'd0);
        read_reg(2'd1, rd);
        check("R10 saved in reset", rd, 32'd0);
        rst_n = 1'b1;
        tick();

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule